// File: doc/BRIEF.md
# Flag-Generating Integer ALU

This block is the integer execution stage for a two-operand register machine. The destination operand is also the first source. Each operation takes the destination value, a source value, a four-bit operation code and a two-bit size select, and works at a width of 8, 16 or 32 bits. It returns a result, which is zero-extended to 32 bits, and a write-back enable that tells the register file whether the result replaces the destination. The datapath is purely combinational, so the result and the enable follow the inputs within the same cycle.

The five status flags are held in a register inside the block. When an operation is issued, the flag register is updated on the next rising clock edge. Each operation code carries its own update mask, and any flag outside that mask keeps its previous value. Compare and test compute a subtraction and an AND only to produce flags, so they never assert the write-back enable. A controller issues at most one operation per cycle and reads the flags from the output port one cycle after issue.

Top module: `iflag_alu`

## Requirements
- R1: Size code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 32 bits. Operands are truncated to the selected width, `res` bits above that width are always 0, and every flag is computed at that width.
- R2: Arithmetic opcodes produce these results: 0 = dst+src, 1 = dst-src, 2 = 0-dst, 3 = dst+1.
- R3: Logical opcodes produce these results: 4 = AND, 5 = OR, 6 = XOR, 7 = bitwise NOT of dst.
- R4: Shift opcodes take their count from `src[4:0]`: 8 = shift left, 9 = arithmetic shift right, 10 = logical shift right, 11 = rotate left. Counts at or beyond the width give 0 for left and logical-right shifts and a fill of the sign bit for arithmetic-right shifts. A rotate turns by the count modulo the width.
- R5: Opcode 12 (compare, dst-src) and opcode 13 (test, dst AND src) update flags exactly as opcodes 1 and 4 do, hold `wb_en` low and drive `res` to 0. Opcodes 14 and 15 hold `wb_en` low, drive `res` to 0 and change no flag. For opcodes 0 to 11, `wb_en` equals `issue`.
- R6: The flag vector is laid out as bit 0 = carry, bit 1 = parity, bit 2 = zero, bit 3 = sign, bit 4 = overflow. Sign is the top bit of the result at the selected width. Zero is set when that result is 0. Parity is set when the result's low byte has an even number of ones.
- R7: For add, carry is the unsigned carry out. For subtract and compare, carry is the borrow (dst < src unsigned). For negate, carry is set when dst is not 0. Overflow is two's-complement overflow of the operation.
- R8: Increment keeps the carry flag and updates overflow, sign, zero and parity.
- R9: AND, OR, XOR and test clear carry and overflow and update sign, zero and parity. NOT changes no flag.
- R10: A shift or rotate with count 0 changes no flag. Otherwise carry takes the last bit shifted out: a bit beyond the operand reads as 0, or as the sign bit for an arithmetic right shift. For a rotate, carry is result bit 0. Shifts also update sign, zero and parity and keep overflow. A rotate updates only carry.
- R11: `flags` is 0 after reset. It changes only at a rising edge with `issue` high, and it holds while `issue` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | An operation is presented this cycle |
| opc | input | 4 | Operation code |
| osize | input | 2 | Operand size select |
| dst_val | input | 32 | Destination operand and first source |
| src_val | input | 32 | Second source, or the shift count in bits 4:0 |
| res | output | 32 | Result, zero-extended from the selected width |
| wb_en | output | 1 | Write the result back to the destination |
| flags | output | 5 | Status flags: overflow, sign, zero, parity, carry (bit 4 down to 0) |

## Verification
The bound properties assume that `issue`, `opc` and `osize` are stable and defined at every rising edge once reset is released. They also assume that the flags are only meaningful one cycle after an issue. The bench meets this by changing inputs only on falling edges and by keeping `issue` low through reset. Stimulus then mixes directed corner cases with random operations over all sixteen opcodes, all four size codes and cycles with `issue` low. The random operations include reserved opcodes and shift counts above the selected width, so the properties are exercised in those states as well.

// File: rtl/ialu_pkg.sv
// Package: shared constants, opcode values, flag bit positions and
// width-selection helpers for the integer ALU.
// Assumes a 32-bit datapath; byte and word views are the low bits.
package ialu_pkg;

    localparam int XLEN    = 32;
    localparam int BYTE_W  = 8;
    localparam int HALF_W  = 16;
    localparam int OPC_W   = 4;
    localparam int SZ_W    = 2;
    localparam int FLAG_W  = 5;
    localparam int SHAMT_W = 5;

    // Operation codes
    localparam logic [OPC_W-1:0] OP_ADD = 4'd0;
    localparam logic [OPC_W-1:0] OP_SUB = 4'd1;
    localparam logic [OPC_W-1:0] OP_NEG = 4'd2;
    localparam logic [OPC_W-1:0] OP_INC = 4'd3;
    localparam logic [OPC_W-1:0] OP_AND = 4'd4;
    localparam logic [OPC_W-1:0] OP_OR  = 4'd5;
    localparam logic [OPC_W-1:0] OP_XOR = 4'd6;
    localparam logic [OPC_W-1:0] OP_NOT = 4'd7;
    localparam logic [OPC_W-1:0] OP_SHL = 4'd8;
    localparam logic [OPC_W-1:0] OP_SAR = 4'd9;
    localparam logic [OPC_W-1:0] OP_SHR = 4'd10;
    localparam logic [OPC_W-1:0] OP_ROL = 4'd11;
    localparam logic [OPC_W-1:0] OP_CMP = 4'd12;
    localparam logic [OPC_W-1:0] OP_TST = 4'd13;

    // Size codes (3 behaves as long)
    localparam logic [SZ_W-1:0] SZ_BYTE = 2'd0;
    localparam logic [SZ_W-1:0] SZ_WORD = 2'd1;
    localparam logic [SZ_W-1:0] SZ_LONG = 2'd2;

    // Flag bit positions
    localparam int FL_CF = 0;
    localparam int FL_PF = 1;
    localparam int FL_ZF = 2;
    localparam int FL_SF = 3;
    localparam int FL_OF = 4;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [FLAG_W-1:0] flags_t;

    localparam flags_t UPD_ALL   = '1;
    localparam flags_t UPD_NONE  = '0;
    localparam flags_t UPD_NOCF  = flags_t'((1 << FL_OF) | (1 << FL_SF) | (1 << FL_ZF) | (1 << FL_PF));
    localparam flags_t UPD_NOOF  = flags_t'((1 << FL_CF) | (1 << FL_SF) | (1 << FL_ZF) | (1 << FL_PF));
    localparam flags_t UPD_CFONLY = flags_t'(1 << FL_CF);

    // Mask keeping only the bits of the selected width
    function automatic word_t width_mask(input logic [SZ_W-1:0] sz);
        case (sz)
            SZ_BYTE: width_mask = word_t'({BYTE_W{1'b1}});
            SZ_WORD: width_mask = word_t'({HALF_W{1'b1}});
            default: width_mask = '1;
        endcase
    endfunction

    // Most significant bit at the selected width
    function automatic logic top_bit(input word_t v, input logic [SZ_W-1:0] sz);
        case (sz)
            SZ_BYTE: top_bit = v[BYTE_W-1];
            SZ_WORD: top_bit = v[HALF_W-1];
            default: top_bit = v[XLEN-1];
        endcase
    endfunction

    // Bit just above the selected width (carry or borrow position)
    function automatic logic above_bit(input logic [XLEN:0] v, input logic [SZ_W-1:0] sz);
        case (sz)
            SZ_BYTE: above_bit = v[BYTE_W];
            SZ_WORD: above_bit = v[HALF_W];
            default: above_bit = v[XLEN];
        endcase
    endfunction

endpackage

// File: rtl/ialu_arith.sv
// Module: adder/subtractor unit for add, subtract, negate, increment
// and compare. Produces the width-masked result, carry/borrow, signed
// overflow and the flag update mask for its opcodes.
// Assumes both operands arrive already masked to the selected width.
module ialu_arith
    import ialu_pkg::*;
(
    input  logic [OPC_W-1:0] op,
    input  logic [SZ_W-1:0]  sz,
    input  word_t            a_in,
    input  word_t            b_in,
    output word_t            r,
    output logic             cf,
    output logic             of,
    output flags_t           upd
);

    word_t         opa;
    word_t         opb;
    logic          do_sub;
    logic [XLEN:0] wide;
    logic          msb_a;
    logic          msb_b;
    logic          msb_r;

    // Operand steering: pick the two adder inputs and the direction
    always_comb begin
        opa    = a_in;
        opb    = b_in;
        do_sub = 1'b0;
        case (op)
            OP_SUB, OP_CMP: do_sub = 1'b1;
            OP_NEG: begin
                opa    = '0;
                opb    = a_in;
                do_sub = 1'b1;
            end
            OP_INC:  opb = word_t'(1);
            default: ;
        endcase
    end

    // Add or subtract one bit wider than the datapath to expose carry
    always_comb begin
        if (do_sub) begin
            wide = {1'b0, opa} - {1'b0, opb};
        end else begin
            wide = {1'b0, opa} + {1'b0, opb};
        end
    end

    // Result, carry and overflow at the selected width
    always_comb begin
        r     = wide[XLEN-1:0] & width_mask(sz);
        cf    = above_bit(wide, sz);
        msb_a = top_bit(opa, sz);
        msb_b = top_bit(opb, sz);
        msb_r = top_bit(r, sz);
        if (do_sub) begin
            of = (msb_a != msb_b) && (msb_r != msb_a);
        end else begin
            of = (msb_a == msb_b) && (msb_r != msb_a);
        end
    end

    // Flag update mask for the arithmetic opcodes
    always_comb begin
        case (op)
            OP_ADD, OP_SUB, OP_NEG, OP_CMP: upd = UPD_ALL;
            OP_INC:                         upd = UPD_NOCF;
            default:                        upd = UPD_NONE;
        endcase
    end

endmodule

// File: rtl/ialu_logic.sv
// Module: bitwise unit for AND, OR, XOR, NOT and test. Carry and
// overflow outputs are cleared for every flag-writing logical opcode.
// Assumes operands arrive already masked to the selected width.
module ialu_logic
    import ialu_pkg::*;
(
    input  logic [OPC_W-1:0] op,
    input  logic [SZ_W-1:0]  sz,
    input  word_t            a_in,
    input  word_t            b_in,
    output word_t            r,
    output logic             cf,
    output logic             of,
    output flags_t           upd
);

    // Bitwise result and flag mask per opcode
    always_comb begin
        cf = 1'b0;
        of = 1'b0;
        case (op)
            OP_AND, OP_TST: begin
                r   = a_in & b_in;
                upd = UPD_ALL;
            end
            OP_OR: begin
                r   = a_in | b_in;
                upd = UPD_ALL;
            end
            OP_XOR: begin
                r   = a_in ^ b_in;
                upd = UPD_ALL;
            end
            OP_NOT: begin
                r   = ~a_in & width_mask(sz);
                upd = UPD_NONE;
            end
            default: begin
                r   = '0;
                upd = UPD_NONE;
            end
        endcase
    end

endmodule

// File: rtl/ialu_shift.sv
// Module: shifter and rotator for shift-left, arithmetic and logical
// shift-right and rotate-left. Carry is the last bit moved out.
// Assumes the operand is masked to the selected width and the count
// is already reduced to its low five bits.
module ialu_shift
    import ialu_pkg::*;
(
    input  logic [OPC_W-1:0]   op,
    input  logic [SZ_W-1:0]    sz,
    input  word_t              a_in,
    input  logic [SHAMT_W-1:0] cnt,
    output word_t              r,
    output logic               cf,
    output logic               of,
    output flags_t             upd
);

    localparam int DBL = 2 * XLEN;

    word_t          sext;
    word_t          rep;
    word_t          rot;
    logic [DBL-1:0] lext;
    logic [DBL-1:0] rext;
    logic [DBL-1:0] aext;

    // Sign-extend and replicate the operand to fill the full datapath
    always_comb begin
        case (sz)
            SZ_BYTE: begin
                sext = {{(XLEN-BYTE_W){a_in[BYTE_W-1]}}, a_in[BYTE_W-1:0]};
                rep  = {(XLEN/BYTE_W){a_in[BYTE_W-1:0]}};
            end
            SZ_WORD: begin
                sext = {{(XLEN-HALF_W){a_in[HALF_W-1]}}, a_in[HALF_W-1:0]};
                rep  = {(XLEN/HALF_W){a_in[HALF_W-1:0]}};
            end
            default: begin
                sext = a_in;
                rep  = a_in;
            end
        endcase
    end

    // Double-width shifts keep the shifted-out bits next to the result
    always_comb begin
        lext = {{XLEN{1'b0}}, a_in} << cnt;
        rext = {a_in, {XLEN{1'b0}}} >> cnt;
        aext = DBL'($signed({sext, {XLEN{1'b0}}}) >>> cnt);
        rot  = (rep << cnt) | (rep >> (XLEN - int'(cnt)));
    end

    // Result, carry and flag mask per opcode
    always_comb begin
        of = 1'b0;
        case (op)
            OP_SHL: begin
                r  = lext[XLEN-1:0] & width_mask(sz);
                cf = above_bit(lext[XLEN:0], sz);
            end
            OP_SHR: begin
                r  = rext[DBL-1:XLEN];
                cf = rext[XLEN-1];
            end
            OP_SAR: begin
                r  = aext[DBL-1:XLEN] & width_mask(sz);
                cf = aext[XLEN-1];
            end
            OP_ROL: begin
                r  = rot & width_mask(sz);
                cf = rot[0];
            end
            default: begin
                r  = '0;
                cf = 1'b0;
            end
        endcase
        if (cnt == '0) begin
            upd = UPD_NONE;
        end else if (op == OP_ROL) begin
            upd = UPD_CFONLY;
        end else if (op == OP_SHL || op == OP_SHR || op == OP_SAR) begin
            upd = UPD_NOOF;
        end else begin
            upd = UPD_NONE;
        end
    end

endmodule

// File: rtl/ialu_flagreg.sv
// Module: derives sign, zero and parity from the selected result and
// merges them with carry and overflow into the flag register under
// the per-opcode update mask.
// Assumes the result is already masked to the selected width.
module ialu_flagreg
    import ialu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [SZ_W-1:0] sz,
    input  word_t           r,
    input  logic            cf,
    input  logic            of,
    input  flags_t          upd,
    output flags_t          flags_q
);

    flags_t nf;

    // Candidate flag vector for the current operation
    always_comb begin
        nf        = '0;
        nf[FL_CF] = cf;
        nf[FL_PF] = ~^r[BYTE_W-1:0];
        nf[FL_ZF] = (r == '0);
        nf[FL_SF] = top_bit(r, sz);
        nf[FL_OF] = of;
    end

    // Masked update of the architectural flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (en) begin
            flags_q <= (flags_q & ~upd) | (nf & upd);
        end
    end

endmodule

// File: rtl/iflag_alu.sv
// Module: top of the flag-generating integer ALU. Masks operands to the
// selected width, routes them to the arithmetic, logical and shift
// units, selects one result, drives write-back and updates flags.
// Assumes at most one operation is issued per cycle; flags reflect the
// issued operation from the following cycle on.
module iflag_alu
    import ialu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [OPC_W-1:0]  opc,
    input  logic [SZ_W-1:0]   osize,
    input  logic [XLEN-1:0]   dst_val,
    input  logic [XLEN-1:0]   src_val,
    output logic [XLEN-1:0]   res,
    output logic              wb_en,
    output logic [FLAG_W-1:0] flags
);

    typedef enum logic [1:0] {
        U_NONE  = 2'd0,
        U_ARITH = 2'd1,
        U_LOGIC = 2'd2,
        U_SHIFT = 2'd3
    } unit_e;

    localparam int N_UNIT = 3;

    word_t  dm;
    word_t  sm;
    unit_e  unit_sel;
    logic   writes;

    word_t  u_r   [N_UNIT];
    logic   u_cf  [N_UNIT];
    logic   u_of  [N_UNIT];
    flags_t u_upd [N_UNIT];

    word_t  sel_r;
    logic   sel_cf;
    logic   sel_of;
    flags_t sel_upd;

    // Truncate both operands to the selected width
    always_comb begin
        dm = dst_val & width_mask(osize);
        sm = src_val & width_mask(osize);
    end

    // Decode which unit owns the opcode and whether it writes back
    always_comb begin
        case (opc)
            OP_ADD, OP_SUB, OP_NEG, OP_INC, OP_CMP: unit_sel = U_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_NOT, OP_TST:  unit_sel = U_LOGIC;
            OP_SHL, OP_SAR, OP_SHR, OP_ROL:         unit_sel = U_SHIFT;
            default:                                unit_sel = U_NONE;
        endcase
        writes = (unit_sel != U_NONE) && (opc != OP_CMP) && (opc != OP_TST);
    end

    ialu_arith u_arith (
        .op   (opc),
        .sz   (osize),
        .a_in (dm),
        .b_in (sm),
        .r    (u_r[0]),
        .cf   (u_cf[0]),
        .of   (u_of[0]),
        .upd  (u_upd[0])
    );

    ialu_logic u_logic (
        .op   (opc),
        .sz   (osize),
        .a_in (dm),
        .b_in (sm),
        .r    (u_r[1]),
        .cf   (u_cf[1]),
        .of   (u_of[1]),
        .upd  (u_upd[1])
    );

    ialu_shift u_shift (
        .op   (opc),
        .sz   (osize),
        .a_in (dm),
        .cnt  (src_val[SHAMT_W-1:0]),
        .r    (u_r[2]),
        .cf   (u_cf[2]),
        .of   (u_of[2]),
        .upd  (u_upd[2])
    );

    // Select the outputs of the owning unit
    always_comb begin
        sel_r   = '0;
        sel_cf  = 1'b0;
        sel_of  = 1'b0;
        sel_upd = UPD_NONE;
        for (int k = 0; k < N_UNIT; k++) begin
            if (int'(unit_sel) == k + 1) begin
                sel_r   = u_r[k];
                sel_cf  = u_cf[k];
                sel_of  = u_of[k];
                sel_upd = u_upd[k];
            end
        end
    end

    // Result and write-back enable at the block edge
    always_comb begin
        res   = writes ? sel_r : '0;
        wb_en = issue && writes;
    end

    ialu_flagreg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (issue),
        .sz      (osize),
        .r       (sel_r),
        .cf      (sel_cf),
        .of      (sel_of),
        .upd     (sel_upd),
        .flags_q (flags)
    );

endmodule

// File: rtl/iflag_alu_chk.sv
// Module: property checker bound to the ALU top. Observes ports only.
// Assumes inputs are stable at each rising edge once reset is released.
module iflag_alu_chk
    import ialu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              issue,
    input logic [OPC_W-1:0]  opc,
    input logic [SZ_W-1:0]   osize,
    input logic [XLEN-1:0]   dst_val,
    input logic [XLEN-1:0]   src_val,
    input logic [XLEN-1:0]   res,
    input logic              wb_en,
    input logic [FLAG_W-1:0] flags
);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(flags));

    // R9
    not_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opc == OP_NOT) |=> $stable(flags));

    // R9
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (opc == OP_AND || opc == OP_OR || opc == OP_XOR || opc == OP_TST))
        |=> (flags[FL_CF] == 1'b0 && flags[FL_OF] == 1'b0));

    // R8
    inc_keep_cf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opc == OP_INC) |=> (flags[FL_CF] == $past(flags[FL_CF])));

    // R10
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opc >= OP_SHL && opc <= OP_ROL && src_val[SHAMT_W-1:0] == '0)
        |=> $stable(flags));

    // R5
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OP_CMP || opc == OP_TST || opc > OP_TST) |-> (!wb_en && res == '0));

    // R1
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osize == SZ_BYTE) |-> (res[XLEN-1:BYTE_W] == '0));

    // R1
    word_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osize == SZ_WORD) |-> (res[XLEN-1:HALF_W] == '0));

    // R10
    rol_only_cf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opc == OP_ROL) |=> (flags[FLAG_W-1:1] == $past(flags[FLAG_W-1:1])));

endmodule

bind iflag_alu iflag_alu_chk chk_i (.*);

// File: tb/iflag_alu_test.sv
`timescale 1ns/1ps
module iflag_alu_test;

    logic        clk;
    logic        rst_n;
    logic        issue;
    logic [3:0]  opc;
    logic [1:0]  osize;
    logic [31:0] dst_val;
    logic [31:0] src_val;
    logic [31:0] res;
    logic        wb_en;
    logic [4:0]  flags;

    int n_tests = 0;
    int n_fail  = 0;
    logic [4:0] mflags;
    string flag_tag;
    bit done = 0;

    iflag_alu uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (issue),
        .opc     (opc),
        .osize   (osize),
        .dst_val (dst_val),
        .src_val (src_val),
        .res     (res),
        .wb_en   (wb_en),
        .flags   (flags)
    );

    initial clk = 0;
    always #10 clk = ~clk;

    task automatic check(input string tag, input string what,
                         input longint unsigned act, input longint unsigned exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: one operation, bit-serial shifts
    task automatic model(input logic [3:0] op, input logic [1:0] sz,
                         input logic [31:0] d, input logic [31:0] s,
                         output logic [31:0] er, output bit ewr,
                         inout logic [4:0] fl);
        int w, c, ones;
        longint unsigned mk, a, b, r, sb, t;
        bit cf, of, zf, sf, pf;
        logic [4:0] um, nf;
        w  = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        mk = (64'd1 << w) - 1;
        sb = 64'd1 << (w - 1);
        a  = d & mk;
        b  = s & mk;
        c  = int'(s[4:0]);
        r = 0; cf = 0; of = 0; um = 5'b00000;
        case (op)
            0: begin t = a + b; cf = ((t >> w) & 1) != 0; r = t & mk;
                     of = ((a & sb) == (b & sb)) && ((r & sb) != (a & sb)); um = 5'b11111; end
            1, 12: begin r = (a - b) & mk; cf = a < b;
                     of = ((a & sb) != (b & sb)) && ((r & sb) != (a & sb)); um = 5'b11111; end
            2: begin r = (0 - a) & mk; cf = a != 0; of = a == sb; um = 5'b11111; end
            3: begin r = (a + 1) & mk; of = a == sb - 1; um = 5'b11110; end
            4, 13: begin r = a & b; um = 5'b11111; end
            5: begin r = a | b; um = 5'b11111; end
            6: begin r = a ^ b; um = 5'b11111; end
            7: begin r = ~a & mk; end
            8, 9, 10, 11: begin
                r = a;
                for (int i = 0; i < c; i++) begin
                    if (op == 8) begin cf = ((r >> (w - 1)) & 1) != 0; r = (r << 1) & mk; end
                    else if (op == 10) begin cf = (r & 1) != 0; r = r >> 1; end
                    else if (op == 9) begin cf = (r & 1) != 0; r = (r >> 1) | (r & sb); end
                    else begin r = ((r << 1) & mk) | ((r >> (w - 1)) & 1); cf = (r & 1) != 0; end
                end
                if (c != 0) um = (op == 11) ? 5'b00001 : 5'b01111;
            end
            default: ;
        endcase
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'((r >> i) & 1);
        zf = (r == 0);
        sf = (r & sb) != 0;
        pf = (ones % 2) == 0;
        nf = {of, sf, zf, pf, cf};
        fl = (fl & ~um) | (nf & um);
        ewr = (op <= 11);
        er  = ewr ? r[31:0] : 32'h0;
    endtask

    function automatic string res_tag(input logic [3:0] op, input logic [1:0] sz);
        if (sz < 2) return "R1";
        if (op <= 3) return "R2";
        if (op <= 7) return "R3";
        if (op <= 11) return "R4";
        return "R5";
    endfunction

    function automatic string flg_tag(input logic [3:0] op, input bit iss);
        if (!iss || op >= 14) return "R11";
        if (op == 0) return "R6";
        if (op == 1 || op == 2) return "R7";
        if (op == 3) return "R8";
        if (op <= 7) return "R9";
        if (op <= 11) return "R10";
        return "R5";
    endfunction

    // Apply one cycle: check flags of the previous cycle, drive, check outputs
    task automatic step(input logic [3:0] op, input logic [1:0] sz,
                        input logic [31:0] d, input logic [31:0] s, input bit iss);
        logic [31:0] er;
        bit ewr;
        logic [4:0] fcopy;
        @(negedge clk);
        check(flag_tag, "flags", flags, mflags);
        issue = iss; opc = op; osize = sz; dst_val = d; src_val = s;
        #1;
        fcopy = mflags;
        model(op, sz, d, s, er, ewr, fcopy);
        if (iss) mflags = fcopy;
        check(res_tag(op, sz), "res", res, er);
        check("R5", "wb_en", wb_en, iss && ewr);
        flag_tag = flg_tag(op, iss);
    endtask

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; issue = 0; opc = 0; osize = 0; dst_val = 0; src_val = 0;
        mflags = 5'b0; flag_tag = "R11";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check("R11", "reset flags", flags, 5'b0);

        // R6 R7: byte add overflow into sign, then carry out to zero
        step(0, 0, 32'hFFFF_FF7F, 32'h1, 1);
        step(0, 0, 32'h0000_00FF, 32'h1, 1);
        // R7: word borrow, long negate of the most negative value
        step(1, 1, 32'h0, 32'h1, 1);
        step(2, 2, 32'h8000_0000, 32'h0, 1);
        step(2, 3, 32'h0, 32'h0, 1);
        // R8: carry set first, then increment past max positive keeps it
        step(0, 2, 32'hFFFF_FFFF, 32'h1, 1);
        step(3, 2, 32'h7FFF_FFFF, 32'h0, 1);
        // R9: AND clears carry/overflow, NOT leaves flags alone
        step(0, 0, 32'h80, 32'h80, 1);
        step(7, 1, 32'h1234_00FF, 32'h0, 1);
        step(4, 0, 32'hF0, 32'h0F, 1);
        // R5: compare and test set flags without write-back
        step(12, 1, 32'h5, 32'h7, 1);
        step(13, 2, 32'h8000_0001, 32'h8000_0000, 1);
        // R4 R10: counts beyond width, rotate modulo width, zero count
        step(8, 0, 32'h81, 32'd9, 1);
        step(8, 0, 32'h81, 32'd8, 1);
        step(9, 0, 32'h80, 32'd20, 1);
        step(10, 1, 32'h8001, 32'd16, 1);
        step(11, 1, 32'h8001, 32'd17, 1);
        step(11, 2, 32'h8000_0000, 32'd1, 1);
        step(8, 2, 32'hFFFF_FFFF, 32'h20, 1);
        // R5 R11: reserved opcodes and idle cycles change nothing
        step(14, 2, 32'h0, 32'h0, 1);
        step(15, 0, 32'hFF, 32'hFF, 1);
        step(0, 2, 32'h0, 32'h0, 0);

        for (int n = 0; n < 1500; n++) begin
            logic [31:0] s;
            s = $urandom();
            if (n % 3 == 0) s = s & 32'h1F;
            step(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
                 $urandom(), s, ($urandom_range(0, 7) != 0));
        end
        @(negedge clk);
        check(flag_tag, "flags", flags, mflags);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule